// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates the interrupt requests of a small processor core. It takes a set of maskable request lines (32 by default), a trap source and a reset-interrupt source. It picks one winner and offers its vector number to the CPU. Each maskable vector carries a 2-bit software priority, held in a small write port. When several requests share the highest pending priority, a fixed hardware order decides: the lowest vector index wins. Vector 0 therefore holds the top rank, which suits a dedicated top-level external line. Grouped external lines are assumed to be merged upstream into one request per vector.

The controller keeps a running priority level. Code 0 is the main program, and codes 1 to 3 are the three handler levels. A maskable request is offered only when its priority is strictly above the running level and the global mask is clear. When the CPU acknowledges, the running level is saved on an internal stack of four entries and raised to the level of the accepted vector. A return strobe pops the stack.

The trap source ignores the mask and the priorities. The reset-interrupt source outranks everything and clears the nesting state. The offered vector is a combinational function of the request inputs and the registered state. The level change takes effect at the clock edge that ends the acknowledge or return cycle.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset, `vec_valid_o` is low with no request, `run_lvl_o` is 0 (main program), and every vector priority is 3.
- R2: Among eligible maskable requests the highest priority wins. Ties go to the lowest vector index. Maskable vector n is presented as `vec_id_o` = n + 2.
- R3: A maskable request is eligible only if its priority code is strictly greater than `run_lvl_o`. A vector with priority code 0 is therefore never offered.
- R4: While `glob_mask_i` is high, no maskable vector is offered. A trap is still offered as `vec_id_o` = 1.
- R5: When `vec_ack_i` is high in a cycle with `vec_valid_o` high for a maskable vector, `run_lvl_o` equals that vector's priority from the next cycle on. The previous level is saved.
- R6: `iret_i` restores the most recently saved level in the next cycle. With nothing saved, `iret_i` leaves `run_lvl_o` unchanged. With neither an acknowledge nor a return, `run_lvl_o` holds.
- R7: A trap outranks every maskable request and is offered as `vec_id_o` = 1. Its acknowledge saves the level and sets `run_lvl_o` to 3. A trap is not offered while four levels are already saved.
- R8: A reset-interrupt request is always offered as `vec_id_o` = 0, ahead of trap and maskable requests. Its acknowledge sets `run_lvl_o` to 0 and discards all saved levels, so a later `iret_i` has no effect.
- R9: `vec_valid_o` follows the requests in the same cycle. A request withdrawn before acknowledge produces no vector and changes no level.
- R10: `vec_ack_i` is ignored while `vec_valid_o` is low. When acknowledge and `iret_i` come in the same cycle, the acknowledge is taken and the return is dropped.
- R11: A priority written through the register port (`cfg_we_i`, `cfg_addr_i`, `cfg_prio_i`) governs arbitration from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_req_i | input | NUM_VEC | Maskable request lines, held until acknowledged |
| trap_i | input | 1 | Non-maskable trap request |
| rst_src_i | input | 1 | Reset-interrupt request |
| glob_mask_i | input | 1 | Global mask for maskable requests |
| cfg_we_i | input | 1 | Priority write strobe |
| cfg_addr_i | input | $clog2(NUM_VEC) | Vector index to write |
| cfg_prio_i | input | 2 | Priority code to write (0 to 3) |
| vec_ack_i | input | 1 | CPU accepts the offered vector |
| iret_i | input | 1 | Return-from-interrupt strobe |
| vec_valid_o | output | 1 | A vector is offered |
| vec_id_o | output | $clog2(NUM_VEC+2) | Offered vector: 0 reset, 1 trap, n+2 maskable n |
| run_lvl_o | output | 2 | Current running priority level |

## Verification
`vec_valid_o` and `vec_id_o` are due in the same cycle as the request, mask and level inputs that produce them. `run_lvl_o` moves one cycle after an acknowledge or return, and a priority write governs the cycle after it. The driver changes inputs just after a rising edge and queues the expected offer together with the level that should hold in that cycle. The monitor compares at the following falling edge. A level change caused by an acknowledge or a return is therefore checked by the next queued item, never by the item of the cycle that caused it.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
    localparam int LVL_W = 2;
    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_MAIN = 2'd0;
    localparam lvl_t LVL_TOP  = 2'd3;
    localparam int   NUM_LVL  = 4;

    localparam int ID_RESET = 0;
    localparam int ID_TRAP  = 1;
    localparam int ID_BASE  = 2;
endpackage

// File: rtl/nirq_prio_regs.sv
module nirq_prio_regs
    import nirq_pkg::*;
#(
    parameter int NUM_VEC = 32,
    localparam int ADDR_W = $clog2(NUM_VEC)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      we_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  lvl_t                      wdata_i,
    output lvl_t [NUM_VEC-1:0]        prio_o
);
    typedef struct packed {
        lvl_t [NUM_VEC-1:0] prio;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we_i && (int'(addr_i) < NUM_VEC)) begin
            r_d.prio[addr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < NUM_VEC; i++) begin
                r_q.prio[i] <= LVL_TOP;
            end
        end else begin
            r_q <= r_d;
        end
    end

    assign prio_o = r_q.prio;
endmodule

// File: rtl/nirq_arbiter.sv
module nirq_arbiter
    import nirq_pkg::*;
#(
    parameter int NUM_VEC = 32,
    localparam int ADDR_W = $clog2(NUM_VEC)
) (
    input  logic [NUM_VEC-1:0]        req_i,
    input  lvl_t [NUM_VEC-1:0]        prio_i,
    input  lvl_t                      run_lvl_i,
    input  logic                      mask_i,
    output logic                      valid_o,
    output logic [ADDR_W-1:0]         idx_o,
    output lvl_t                      lvl_o
);
    // One request vector per software level; level 0 can never preempt.
    logic [NUM_LVL-1:0][NUM_VEC-1:0] hit;

    assign hit[0] = '0;

    for (genvar gl = 1; gl < NUM_LVL; gl++) begin : g_lvl
        for (genvar gv = 0; gv < NUM_VEC; gv++) begin : g_vec
            assign hit[gl][gv] = req_i[gv] && !mask_i
                               && (prio_i[gv] == lvl_t'(gl))
                               && (lvl_t'(gl) > run_lvl_i);
        end
    end

    logic [NUM_VEC-1:0] sel;

    always_comb begin
        sel     = '0;
        lvl_o   = LVL_MAIN;
        valid_o = 1'b0;
        for (int l = 1; l < NUM_LVL; l++) begin
            if (|hit[l]) begin
                sel     = hit[l];
                lvl_o   = lvl_t'(l);
                valid_o = 1'b1;
            end
        end
        idx_o = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (sel[i]) begin
                idx_o = ADDR_W'(i);
            end
        end
    end
endmodule

// File: rtl/nirq_level_stack.sv
module nirq_level_stack
    import nirq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic push_i,
    input  logic pop_i,
    input  logic clear_i,
    input  lvl_t lvl_i,
    output lvl_t run_lvl_o,
    output logic full_o
);
    typedef struct packed {
        lvl_t [DEPTH-1:0]  slot;
        logic [CNT_W-1:0]  cnt;
        lvl_t              run;
    } stk_t;

    stk_t s_d, s_q;
    logic full, empty;

    assign full  = (s_q.cnt == CNT_W'(DEPTH));
    assign empty = (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d.cnt = '0;
            s_d.run = LVL_MAIN;
        end else if (push_i) begin
            if (!full) begin
                s_d.slot[IDX_W'(s_q.cnt)] = s_q.run;
                s_d.cnt                   = s_q.cnt + 1'b1;
            end
            s_d.run = lvl_i;
        end else if (pop_i && !empty) begin
            s_d.cnt = s_q.cnt - 1'b1;
            s_d.run = s_q.slot[IDX_W'(s_q.cnt - 1'b1)];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_lvl_o = s_q.run;
    assign full_o    = full;
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
    import nirq_pkg::*;
#(
    parameter int NUM_VEC   = 32,
    parameter int STK_DEPTH = 4,
    localparam int ADDR_W   = $clog2(NUM_VEC),
    localparam int ID_W     = $clog2(NUM_VEC + ID_BASE)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_VEC-1:0] irq_req_i,
    input  logic               trap_i,
    input  logic               rst_src_i,
    input  logic               glob_mask_i,
    input  logic               cfg_we_i,
    input  logic [ADDR_W-1:0]  cfg_addr_i,
    input  logic [1:0]         cfg_prio_i,
    input  logic               vec_ack_i,
    input  logic               iret_i,
    output logic               vec_valid_o,
    output logic [ID_W-1:0]    vec_id_o,
    output logic [1:0]         run_lvl_o
);
    lvl_t [NUM_VEC-1:0] prio;
    lvl_t               run_lvl;
    logic               stk_full;
    logic               arb_valid;
    logic [ADDR_W-1:0]  arb_idx;
    lvl_t               arb_lvl;

    nirq_prio_regs #(.NUM_VEC(NUM_VEC)) prio_regs_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_prio_i),
        .prio_o  (prio)
    );

    nirq_arbiter #(.NUM_VEC(NUM_VEC)) arbiter_i (
        .req_i     (irq_req_i),
        .prio_i    (prio),
        .run_lvl_i (run_lvl),
        .mask_i    (glob_mask_i),
        .valid_o   (arb_valid),
        .idx_o     (arb_idx),
        .lvl_o     (arb_lvl)
    );

    // Offer selection and stack control
    typedef struct packed {
        logic             valid;
        logic [ID_W-1:0]  id;
        lvl_t             new_lvl;
        logic             push;
        logic             pop;
        logic             clear;
    } ctl_t;

    ctl_t c;

    always_comb begin
        c = '0;
        if (rst_src_i) begin
            c.valid   = 1'b1;
            c.id      = ID_W'(ID_RESET);
            c.new_lvl = LVL_MAIN;
        end else if (trap_i && !stk_full) begin
            c.valid   = 1'b1;
            c.id      = ID_W'(ID_TRAP);
            c.new_lvl = LVL_TOP;
        end else if (arb_valid) begin
            c.valid   = 1'b1;
            c.id      = ID_W'(arb_idx) + ID_W'(ID_BASE);
            c.new_lvl = arb_lvl;
        end
        if (vec_ack_i && c.valid) begin
            c.clear = (c.id == ID_W'(ID_RESET));
            c.push  = !c.clear;
        end else begin
            c.pop = iret_i;
        end
    end

    nirq_level_stack #(.DEPTH(STK_DEPTH)) stack_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .push_i    (c.push),
        .pop_i     (c.pop),
        .clear_i   (c.clear),
        .lvl_i     (c.new_lvl),
        .run_lvl_o (run_lvl),
        .full_o    (stk_full)
    );

    assign vec_valid_o = c.valid;
    assign vec_id_o    = c.id;
    assign run_lvl_o   = run_lvl;
endmodule

// File: rtl/nirq_checker.sv
module nirq_checker #(
    parameter int NUM_VEC = 32,
    parameter int ID_W    = 6
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_VEC-1:0] irq_req_i,
    input logic               trap_i,
    input logic               rst_src_i,
    input logic               glob_mask_i,
    input logic               vec_ack_i,
    input logic               iret_i,
    input logic               vec_valid_o,
    input logic [ID_W-1:0]    vec_id_o,
    input logic [1:0]         run_lvl_o
);
    logic take;
    assign take = vec_ack_i && vec_valid_o;

    AST_VALID_NEEDS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_valid_o |-> ((|irq_req_i) || trap_i || rst_src_i)); // R9

    AST_MASK_BLOCKS_MASKABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (glob_mask_i && vec_valid_o) |-> (vec_id_o < ID_W'(2))); // R4

    AST_RESET_SRC_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_src_i |-> (vec_valid_o && vec_id_o == '0)); // R8

    AST_RESET_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take && vec_id_o == '0) |=> (run_lvl_o == 2'd0)); // R8

    AST_TRAP_ACK_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take && vec_id_o == ID_W'(1)) |=> (run_lvl_o == 2'd3)); // R7

    AST_MASKABLE_ACK_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take && vec_id_o >= ID_W'(2)) |=> (run_lvl_o > $past(run_lvl_o))); // R5

    AST_IDLE_LEVEL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!take && !iret_i) |=> $stable(run_lvl_o)); // R6
endmodule

bind nested_irq_ctrl nirq_checker #(.NUM_VEC(NUM_VEC), .ID_W(ID_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_req_i   (irq_req_i),
    .trap_i      (trap_i),
    .rst_src_i   (rst_src_i),
    .glob_mask_i (glob_mask_i),
    .vec_ack_i   (vec_ack_i),
    .iret_i      (iret_i),
    .vec_valid_o (vec_valid_o),
    .vec_id_o    (vec_id_o),
    .run_lvl_o   (run_lvl_o)
);

// File: tb/nested_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module nested_irq_ctrl_tb_top;
    localparam int NV = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NV-1:0] req = '0;
    logic          trap = 1'b0, rsrc = 1'b0, mask = 1'b0;
    logic          we = 1'b0;
    logic [4:0]    addr = '0;
    logic [1:0]    wprio = '0;
    logic          ack = 1'b0, iret = 1'b0;
    logic          vld;
    logic [5:0]    vid;
    logic [1:0]    lvl;

    always #2.5 clk = ~clk;

    nested_irq_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .trap_i(trap),
        .rst_src_i(rsrc), .glob_mask_i(mask), .cfg_we_i(we),
        .cfg_addr_i(addr), .cfg_prio_i(wprio), .vec_ack_i(ack),
        .iret_i(iret), .vec_valid_o(vld), .vec_id_o(vid), .run_lvl_o(lvl)
    );

    typedef struct {
        bit    v;
        int    id;
        int    lv;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // Monitor: compares one queued item per cycle, at the falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (vld !== e.v || (e.v && int'(vid) != e.id) || int'(lvl) != e.lv) begin
                errors++;
                $display("FAIL %s: got vld=%0b id=%0d lvl=%0d, expected vld=%0b id=%0d lvl=%0d",
                         e.tag, vld, vid, lvl, e.v, e.id, e.lv);
            end
        end
    end

    task automatic apply(input logic [NV-1:0] rq, input bit tr, input bit rs,
                         input bit mk, input bit ak, input bit rt,
                         input bit ev, input int eid, input int elv, input string tag);
        exp_t e;
        @(posedge clk); #1;
        req = rq; trap = tr; rsrc = rs; mask = mk; ack = ak; iret = rt;
        e.v = ev; e.id = eid; e.lv = elv; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(input int a, input int p);
        @(posedge clk); #1;
        req = '0; trap = 0; rsrc = 0; mask = 0; ack = 0; iret = 0;
        we = 1; addr = 5'(a); wprio = 2'(p);
        @(posedge clk); #1;
        we = 0;
    endtask

    function automatic logic [NV-1:0] b(input int n);
        return NV'(1) << n;
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        apply('0, 0,0,0,0,0, 0, 0, 0, "R1 idle after reset");
        apply(b(5)|b(9), 0,0,0,0,0, 1, 7, 0, "R2 tie at default level, low index");
        apply(b(0)|b(12), 0,0,0,0,0, 1, 2, 0, "R2 vector 0 top rank");
        wr(5, 1); wr(9, 2); wr(12, 3); wr(20, 0);
        apply(b(5)|b(9), 0,0,0,0,0, 1, 11, 0, "R2 higher priority wins");
        apply(b(5)|b(9)|b(12), 0,0,0,0,0, 1, 14, 0, "R2 top level wins over index");
        apply(b(20), 0,0,0,0,0, 0, 0, 0, "R3 code 0 never offered");
        apply(b(5)|b(9), 0,0,1,0,0, 0, 0, 0, "R4 mask blocks maskable");
        apply(b(5), 1,0,1,0,0, 1, 1, 0, "R4 trap passes mask");
        apply(b(5), 0,0,0,1,0, 1, 7, 0, "R5 ack level-1 vector");
        apply(b(5), 0,0,0,0,0, 0, 0, 1, "R3 R5 equal level not offered");
        apply(b(9), 0,0,0,1,0, 1, 11, 1, "R5 nested ack level 2");
        apply(b(12), 0,0,0,1,0, 1, 14, 2, "R5 nested ack level 3");
        apply(b(9)|b(12), 0,0,0,0,0, 0, 0, 3, "R3 nothing above level 3");
        apply(b(12), 1,0,0,1,0, 1, 1, 3, "R7 trap outranks maskable");
        apply('0, 1,0,0,0,0, 0, 0, 3, "R7 trap held while stack full");
        apply('0, 1,1,0,0,0, 1, 0, 3, "R8 reset source offered first");
        apply('0, 0,0,0,0,1, 0, 0, 3, "R6 return from trap");
        apply('0, 0,0,0,0,1, 0, 0, 3, "R6 restored level 3");
        apply('0, 0,0,0,0,1, 0, 0, 2, "R6 restored level 2");
        apply('0, 0,0,0,0,1, 0, 0, 1, "R6 restored level 1");
        apply('0, 0,0,0,0,1, 0, 0, 0, "R6 return with empty stack");
        apply('0, 0,0,0,0,0, 0, 0, 0, "R6 empty return no change");
        apply('0, 0,0,0,1,0, 0, 0, 0, "R10 ack without offer");
        apply('0, 0,0,0,0,0, 0, 0, 0, "R10 stray ack ignored");
        apply(b(9), 0,0,0,1,1, 1, 11, 0, "R10 ack with return");
        apply('0, 0,0,0,0,0, 0, 0, 2, "R10 return dropped");
        apply('0, 0,0,0,0,1, 0, 0, 2, "R6 return");
        apply(b(9), 0,0,0,0,0, 1, 11, 0, "R9 offer follows request");
        apply('0, 0,0,0,0,0, 0, 0, 0, "R9 withdrawn request no vector");
        apply(b(12), 1,0,0,1,0, 1, 1, 0, "R7 trap ack from main");
        apply('0, 0,0,0,0,0, 0, 0, 3, "R7 trap sets level 3");
        apply('0, 0,0,0,0,1, 0, 0, 3, "R6 leave trap");
        apply(b(5), 0,0,0,1,0, 1, 7, 0, "R5 enter level 1");
        apply(b(12), 0,1,0,1,0, 1, 0, 1, "R8 reset ack");
        apply('0, 0,0,0,0,1, 0, 0, 0, "R8 level cleared");
        apply('0, 0,0,0,0,0, 0, 0, 0, "R8 stack discarded");
        wr(5, 0);
        apply(b(5), 0,0,0,0,0, 0, 0, 0, "R11 write to code 0 disables");
        wr(5, 2);
        apply(b(5)|b(12), 0,0,0,0,0, 1, 14, 0, "R11 write level 2 still below 3");
        apply(b(5), 0,0,0,0,0, 1, 7, 0, "R11 rewritten vector offered");
        apply('0, 0,0,0,0,0, 0, 0, 0, "R1 quiet end");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule